// File: doc/BRIEF.md
# Flash Page-Program Write Buffer

This block collects one full page of write data for a serial NOR flash and then sends it to the flash in a single page-program transaction. Software selects what the shared buffer is used for with a role bit. The bit reads back, and it can be set to read-prefetch use or to program use. Software sets a start address and loads the page as 32-bit words through one data register. It then writes a command code to start the transfer. One chip-select window carries the program opcode, three address bytes (most significant first) and every buffered byte. Each word is streamed low byte first.

A page that is not complete is written one byte at a time with a separate single-byte command. That command is accepted only while the buffer is in read-prefetch use. Software issues the write-enable command and polls the flash busy status itself. A start that the block refuses sets a sticky error flag. The serial side runs in SPI mode 0 at half the block clock, most significant bit first.

Register offsets on `reg_addr`: 0x0 command (write a code; reads back the running code while busy, else 0), 0x1 role (bit 0), 0x2/0x3/0x4 address bits 7:0, 15:8, 23:16, 0x9 address bits 31:24, 0x5 word push, 0x6 single-byte data, 0x7 error flag (bit 0).

Top module: `page_prog_buffer`

## Requirements
- R1: After reset spi_cs_n is 1, spi_sck is 0, and the command, role and error registers read 0.
- R2: The role bit (offset 0x1, bit 0; 0 = read prefetch, 1 = program buffer) reads back the last value written.
- R3: Command code 0x10 accepted while idle starts a transfer whose first bit is on the bus in the cycle after the write. spi_cs_n stays low for the whole transfer. The bytes are 0x02, address[23:16], address[15:8], address[7:0], then 128 data bytes. Each byte goes MSB first, one bit per two clocks (SCK low then high), and spi_cs_n rises in the clock after the last high phase.
- R4: Words are sent in push order, and within a word bits 7:0 go first, then 15:8, 23:16 and 31:24.
- R5: The command register reads 0x10 during a page transfer, 0x90 during a single-byte transfer, and 0 when idle.
- R6: Command 0x10 given with fewer than 32 words loaded, or with the role bit 0, starts nothing and sets the error flag.
- R7: The error flag stays set until bit 0 of a write to offset 0x7 is 1. A write with bit 0 = 0 leaves it set.
- R8: The word pointer returns to zero when a page transfer completes and when any address register is written.
- R9: Word pushes are ignored while the role bit is 0 or once 32 words are held.
- R10: Command 0x90 with the role bit 0 sends 0x02, three address bytes and the single-byte data register. With the role bit 1 it starts nothing and sets the error flag.
- R11: While a transfer runs, writes to the command, role, address, word and byte registers are ignored.
- R12: The address bits 31:24 register (offset 0x9) is stored and reads back but is not transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Register offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Flash serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |

## Verification
A register write takes effect at the clock edge that samples it. Read data is combinational, so the bench reads one clock later, away from the edge. An accepted start drives chip select low and puts the first bit on the bus in the next cycle. Each bit then takes exactly two cycles. The bench expands every accepted command into the exact per-cycle sequence of chip select, clock and data, and checks it at every falling edge. It also decides whether a later write lands while the block is busy from the last cycle it compared, so refused and ignored writes are judged on the same cycle the design judges them.

// File: rtl/page_prog_buffer.sv
module page_prog_buffer #(
  parameter int PAGE_BYTES = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi
);
  localparam int WORDS = PAGE_BYTES / 4;
  localparam int WI    = $clog2(WORDS);
  localparam int PW    = $clog2(WORDS + 1);
  localparam int BW    = $clog2(PAGE_BYTES + 4);
  localparam int IW    = $clog2(PAGE_BYTES);

  localparam logic [3:0] OFF_CMD = 4'h0, OFF_ROLE = 4'h1, OFF_A0 = 4'h2, OFF_A1 = 4'h3,
                         OFF_A2 = 4'h4, OFF_WORD = 4'h5, OFF_BYTE = 4'h6, OFF_ERR = 4'h7,
                         OFF_A3 = 4'h9;
  localparam logic [7:0] CODE_PAGE = 8'h10, CODE_BYTE = 8'h90, OP_PROG = 8'h02;

  logic [31:0]   mem [WORDS];
  logic [7:0]    adr [4];
  logic [7:0]    bdata, shreg, nxt_byte;
  logic [PW-1:0] wptr;
  logic [BW-1:0] bytec, nb, last_idx;
  logic [IW-1:0] didx;
  logic [2:0]    bitc;
  logic          role, err, busy, pg, ph;

  wire idle_wr   = reg_wr && !busy;
  wire wr_cmd    = idle_wr && reg_addr == OFF_CMD;
  wire full      = wptr == PW'(WORDS);
  wire is_page   = reg_wdata[7:0] == CODE_PAGE;
  wire is_byte   = reg_wdata[7:0] == CODE_BYTE;
  wire start_pg  = wr_cmd && is_page && role && full;
  wire start_by  = wr_cmd && is_byte && !role;
  wire refuse    = wr_cmd && ((is_page && !(role && full)) || (is_byte && role));
  wire push      = idle_wr && reg_addr == OFF_WORD && role && !full;
  wire adr_wr    = idle_wr && (reg_addr == OFF_A0 || reg_addr == OFF_A1 ||
                               reg_addr == OFF_A2 || reg_addr == OFF_A3);
  wire bit_end   = busy && ph;
  wire byte_end  = bit_end && bitc == 3'd7;
  wire frame_end = byte_end && bytec == last_idx;

  assign last_idx = pg ? BW'(PAGE_BYTES + 3) : BW'(4);
  assign spi_cs_n = ~busy;
  assign spi_sck  = busy & ph;
  assign spi_mosi = shreg[7];

  always_comb begin
    nb   = bytec + 1'b1;
    didx = IW'(nb - BW'(4));
    case (nb)
      BW'(1):  nxt_byte = adr[2];
      BW'(2):  nxt_byte = adr[1];
      BW'(3):  nxt_byte = adr[0];
      default: nxt_byte = pg ? mem[didx[IW-1:2]][{didx[1:0], 3'b000} +: 8] : bdata;
    endcase
  end

  always_ff @(posedge clk)
    if (push) mem[wptr[WI-1:0]] <= reg_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      role <= 1'b0;
      err  <= 1'b0;
      bdata <= '0;
      for (int i = 0; i < 4; i++) adr[i] <= '0;
    end else begin
      if (idle_wr && reg_addr == OFF_ROLE) role <= reg_wdata[0];
      if (idle_wr && reg_addr == OFF_BYTE) bdata <= reg_wdata[7:0];
      if (idle_wr && reg_addr == OFF_A0) adr[0] <= reg_wdata[7:0];
      if (idle_wr && reg_addr == OFF_A1) adr[1] <= reg_wdata[7:0];
      if (idle_wr && reg_addr == OFF_A2) adr[2] <= reg_wdata[7:0];
      if (idle_wr && reg_addr == OFF_A3) adr[3] <= reg_wdata[7:0];
      if (refuse) err <= 1'b1;
      else if (reg_wr && reg_addr == OFF_ERR && reg_wdata[0]) err <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wptr <= '0;
    else if (adr_wr || (frame_end && pg)) wptr <= '0;
    else if (push) wptr <= wptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; pg <= 1'b0; ph <= 1'b0;
      bitc <= '0; bytec <= '0; shreg <= '0;
    end else if (start_pg || start_by) begin
      busy <= 1'b1; pg <= start_pg; ph <= 1'b0;
      bitc <= '0; bytec <= '0; shreg <= OP_PROG;
    end else if (busy) begin
      ph <= ~ph;
      if (frame_end) busy <= 1'b0;
      else if (byte_end) begin
        bytec <= nb;
        shreg <= nxt_byte;
        bitc  <= '0;
      end else if (bit_end) begin
        shreg <= {shreg[6:0], 1'b0};
        bitc  <= bitc + 1'b1;
      end
    end

  always_comb begin
    case (reg_addr)
      OFF_CMD:  reg_rdata = busy ? {24'd0, pg ? CODE_PAGE : CODE_BYTE} : 32'd0;
      OFF_ROLE: reg_rdata = {31'd0, role};
      OFF_A0:   reg_rdata = {24'd0, adr[0]};
      OFF_A1:   reg_rdata = {24'd0, adr[1]};
      OFF_A2:   reg_rdata = {24'd0, adr[2]};
      OFF_A3:   reg_rdata = {24'd0, adr[3]};
      OFF_ERR:  reg_rdata = {31'd0, err};
      default:  reg_rdata = 32'd0;
    endcase
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R3
  AST_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ph) |=> !ph); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wptr <= PW'(WORDS)); // R9
  AST_START_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && pg) |-> ($past(full) && $past(role))); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(reg_wr && reg_addr == OFF_ERR)) |=> err); // R7
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && pg) |-> wptr == '0); // R8
  AST_ROLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(role)); // R11
endmodule

// File: tb/test_page_prog_buffer.sv
module test_page_prog_buffer;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic spi_cs_n, spi_sck, spi_mosi;
  int tests = 0, fails = 0, bus_bad = 0, bus_seen = 0;
  bit frame_q[$];
  bit last_was_frame = 0;
  bit m_role = 0;
  logic [7:0] m_adr [4] = '{default: 8'h00};
  logic [7:0] m_bdata = 0;
  logic [31:0] m_words[$];

  always #10 clk = ~clk;

  page_prog_buffer i_page_prog_buffer (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata,
    .reg_rdata, .spi_cs_n, .spi_sck, .spi_mosi);

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(negedge clk) if (rst_n) begin
    if (frame_q.size() > 0) begin
      bit sck_e, mosi_e;
      sck_e = frame_q.pop_front();
      mosi_e = frame_q.pop_front();
      last_was_frame = 1;
      if (spi_cs_n !== 1'b0 || spi_sck !== sck_e || spi_mosi !== mosi_e) begin
        if (bus_bad == bus_seen) $display("  bus mismatch at %0t: cs=%b sck=%b mosi=%b exp 0 %b %b",
          $time, spi_cs_n, spi_sck, spi_mosi, sck_e, mosi_e);
        bus_bad++;
      end
    end else begin
      last_was_frame = 0;
      if (spi_cs_n !== 1'b1 || spi_sck !== 1'b0) begin
        if (bus_bad == bus_seen) $display("  bus idle mismatch at %0t: cs=%b sck=%b", $time, spi_cs_n, spi_sck);
        bus_bad++;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_check(string req);
    check(req, bus_bad - bus_seen, 0);
    bus_seen = bus_bad;
  endtask

  task automatic add_byte(logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      frame_q.push_back(1'b0); frame_q.push_back(b[k]);
      frame_q.push_back(1'b1); frame_q.push_back(b[k]);
    end
  endtask

  task automatic build_frame(bit page);
    add_byte(8'h02); add_byte(m_adr[2]); add_byte(m_adr[1]); add_byte(m_adr[0]);
    if (page) foreach (m_words[w]) for (int l = 0; l < 4; l++) add_byte(m_words[w][8*l +: 8]);
    else add_byte(m_bdata);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bit busy;
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk);
    busy = last_was_frame;
    #1 reg_wr = 0;
    if (!busy) case (a)
      4'h0: if (d[7:0] == 8'h10 && m_role && m_words.size() == 32) begin
              build_frame(1); m_words.delete();
            end else if (d[7:0] == 8'h90 && !m_role) build_frame(0);
      4'h1: m_role = d[0];
      4'h2: begin m_adr[0] = d[7:0]; m_words.delete(); end
      4'h3: begin m_adr[1] = d[7:0]; m_words.delete(); end
      4'h4: begin m_adr[2] = d[7:0]; m_words.delete(); end
      4'h9: begin m_adr[3] = d[7:0]; m_words.delete(); end
      4'h5: if (m_role && m_words.size() < 32) m_words.push_back(d);
      4'h6: m_bdata = d[7:0];
      default: ;
    endcase
  endtask

  task automatic rd(string req, logic [3:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #2 check(req, reg_rdata, exp);
  endtask

  task automatic wait_idle();
    while (frame_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_addr(logic [31:0] a);
    wr(4'h2, a[7:0]); wr(4'h3, a[15:8]); wr(4'h4, a[23:16]); wr(4'h9, a[31:24]);
  endtask

  task automatic push_n(int n, logic [31:0] seed);
    for (int i = 0; i < n; i++) wr(4'h5, seed ^ (i * 32'h01030507));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd("R1 cmd", 4'h0, 0); rd("R1 role", 4'h1, 0); rd("R1 err", 4'h7, 0);
    check("R1 cs_n", spi_cs_n, 1); check("R1 sck", spi_sck, 0);
    // R6 start with role 0
    wr(4'h0, 32'h10);
    rd("R6 err after refused start", 4'h7, 1);
    repeat (4) @(negedge clk);
    bus_check("R6 no transfer");
    // R7 sticky error
    wr(4'h7, 32'h0);
    rd("R7 err kept", 4'h7, 1);
    wr(4'h7, 32'h1);
    rd("R7 err cleared", 4'h7, 0);
    // R9 push ignored with role 0; R6 short buffer
    wr(4'h5, 32'hDEADBEEF);
    wr(4'h1, 32'h1);
    rd("R2 role readback", 4'h1, 1);
    push_n(31, 32'h11223344);
    wr(4'h0, 32'h10);
    rd("R9 R6 short page refused", 4'h7, 1);
    repeat (4) @(negedge clk);
    bus_check("R6 R9 no transfer");
    wr(4'h7, 32'h1);
    // R3 R4 full page with overflow push
    set_addr(32'h12345678);
    rd("R12 high address readback", 4'h9, 32'h12);
    push_n(32, 32'hA5C30F01);
    wr(4'h5, 32'hFFFFFFFF);
    wr(4'h0, 32'h10);
    rd("R5 busy code page", 4'h0, 32'h10);
    // R11 writes during transfer ignored
    wr(4'h2, 32'h99);
    wr(4'h1, 32'h0);
    wr(4'h0, 32'h90);
    rd("R11 address unchanged", 4'h2, 32'h78);
    rd("R11 role unchanged", 4'h1, 1);
    wait_idle();
    rd("R5 idle code", 4'h0, 0);
    rd("R11 no error from busy write", 4'h7, 0);
    bus_check("R3 R4 R9 R11 R12 page frame");
    // R8 pointer cleared after completion
    push_n(32, 32'h5A5A0000);
    wr(4'h0, 32'h10);
    wait_idle();
    bus_check("R8 second page after completion");
    // R8 pointer cleared by address write
    push_n(5, 32'h0BADF00D);
    set_addr(32'h00ABCDEF);
    push_n(32, 32'h76543210);
    wr(4'h0, 32'h10);
    wait_idle();
    bus_check("R8 page after address reload");
    rd("R8 no error", 4'h7, 0);
    // R10 single byte
    wr(4'h0, 32'h90);
    rd("R10 refused in program role", 4'h7, 1);
    repeat (4) @(negedge clk);
    bus_check("R10 no transfer in program role");
    wr(4'h7, 32'h1);
    wr(4'h1, 32'h0);
    wr(4'h6, 32'h3C);
    set_addr(32'h00010203);
    wr(4'h0, 32'h90);
    rd("R5 busy code byte", 4'h0, 32'h90);
    wait_idle();
    bus_check("R10 single byte frame");
    rd("R10 no error", 4'h7, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule